// File: doc/BRIEF.md
# Register-to-Register Execute Unit with Zero and Carry Flags

This block is the execute stage of a small processor pipeline. Each cycle in which the enable input is high, it accepts one decoded bundle. The bundle either asks for an arithmetic or shift operation on two registers of an internal register file, or asks for a half-word move into one register. The register file is 32 bits wide and holds 16 entries by default. A two-bit flag register holds the zero and carry results of the last arithmetic or shift operation.

Register reads are combinational. Register writes and flag updates happen on the rising clock edge of an enabled cycle. A bundle whose addressing modes the unit cannot carry out raises the fault output in the same cycle, and that bundle changes nothing. An asynchronous inspection port returns any register so that the surrounding logic or a bench can observe results.

The kind field selects the operation: 0 is arithmetic/shift, 1 is move. The operation codes are 0 add, 1 subtract, 2 shift left, 3 shift right and 4 compare; codes 5 to 7 are unsupported. The operand mode codes are 0 immediate, 1 full register, 2 register low half and 3 register high half. In the flags output, bit 0 is zero and bit 1 is carry.

Top module: `alu_exec_unit`

## Requirements
- R1: After reset every register reads 0, the flags read 2'b00 and fault is low.
- R2: Add (kind 0, op 0, all three modes 1) writes first+second modulo 2^32 to the destination and sets carry to the unsigned carry-out of the 32-bit sum.
- R3: Subtract (op 1) writes first-second to the destination and sets carry when the first operand is unsigned-less than the second.
- R4: Compare (op 4) sets zero and carry exactly as subtract would, and writes no register.
- R5: Shift left (op 2) writes the first operand moved left by one place with bit 0 cleared, and loads carry with the old bit 31.
- R6: Shift right (op 3) is logical: it writes the first operand moved right by one place with bit 31 cleared, and loads carry with the old bit 0.
- R7: For every operation of kind 0, flag bit 0 becomes 1 exactly when the 32-bit result is zero.
- R8: A move with destination mode 2 and source mode 0 replaces bits 15:0 of the target with the 16-bit immediate, keeps bits 31:16, and leaves the flags unchanged.
- R9: A move with destination mode 3 and source mode 0 replaces bits 31:16 of the target with the immediate, keeps bits 15:0, and leaves the flags unchanged.
- R10: Fault is high in an enabled cycle when the bundle is kind 0 with any mode other than 1 or an op code above 4, or kind 1 with a destination mode other than 2/3 or a source mode other than 0/1. Such a bundle changes no register and no flag.
- R11: While enable is low, no register or flag changes and fault stays low.
- R12: A move with source mode 1 takes bits 15:0 of the first source register as the half-word to insert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute the presented bundle this cycle |
| op_kind | input | 1 | 0 arithmetic/shift, 1 half-word move |
| alu_op | input | 3 | Arithmetic operation code |
| a_mode | input | 2 | Mode of the first source |
| a_idx | input | 4 | First source register index |
| b_mode | input | 2 | Mode of the second source |
| b_idx | input | 4 | Second source register index |
| d_mode | input | 2 | Mode of the destination |
| d_idx | input | 4 | Destination register index |
| imm | input | 16 | Half-word immediate for moves |
| fault | output | 1 | Unsupported bundle in an enabled cycle |
| flags_q | output | 2 | Bit 0 zero, bit 1 carry |
| peek_idx | input | 4 | Register index for inspection |
| peek_data | output | 32 | Combinational contents of that register |

## Verification
A wrong register value shows up on the inspection port as soon as the bench selects that register. This is one clock edge after the bundle that wrote it, so a masked-write or adder error reaches the ports within a single cycle. A wrong flag state shows up on flags_q right after that same edge. A broken fault decode shows up in the cycle of the bundle itself, and the state that the rejected bundle must not have touched is read back on the following cycle.

// File: rtl/aexu_pkg.sv
`timescale 1ns/1ps
package aexu_pkg;

   typedef enum logic {
      KIND_ALU  = 1'b0,
      KIND_MOVE = 1'b1
   } kind_e;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_SHL = 3'd2,
      OP_SHR = 3'd3,
      OP_CMP = 3'd4
   } alu_op_e;

   typedef enum logic [1:0] {
      MODE_IMM  = 2'd0,
      MODE_REG  = 2'd1,
      MODE_LOW  = 2'd2,
      MODE_HIGH = 2'd3
   } mode_e;

   localparam int FLAG_Z = 0;
   localparam int FLAG_C = 1;
   localparam int FLAG_W = 2;

endpackage

// File: rtl/aexu_regfile.sv
`timescale 1ns/1ps
module aexu_regfile #(
   parameter int W      = 32,
   parameter int NREGS  = 16,
   localparam int IW    = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_a_idx,
   output logic [W-1:0]  rd_a,
   input  logic [IW-1:0] rd_b_idx,
   output logic [W-1:0]  rd_b,
   input  logic [IW-1:0] rd_p_idx,
   output logic [W-1:0]  rd_p,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [W-1:0]  wr_mask
);

   logic [W-1:0] mem [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[g] <= '0;
         end else if (hit) begin
            mem[g] <= (mem[g] & ~wr_mask) | (wr_data & wr_mask);
         end
      end
   end

   assign rd_a = mem[rd_a_idx];
   assign rd_b = mem[rd_b_idx];
   assign rd_p = mem[rd_p_idx];

endmodule

// File: rtl/aexu_alu.sv
`timescale 1ns/1ps
module aexu_alu
   import aexu_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         carry,
   output logic         zero
);

   logic         is_sub;
   logic [W-1:0] arith;
   logic         arith_c;

   assign is_sub = (op == OP_SUB) || (op == OP_CMP);

   if (SHARED_ADDER) begin : g_shared
      logic [W:0]   sum;
      logic [W-1:0] b_eff;
      assign b_eff   = is_sub ? ~b : b;
      assign sum     = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
      assign arith   = sum[W-1:0];
      assign arith_c = is_sub ? ~sum[W] : sum[W];
   end else begin : g_split
      logic [W:0] add_w;
      logic [W:0] sub_w;
      assign add_w   = {1'b0, a} + {1'b0, b};
      assign sub_w   = {1'b0, a} - {1'b0, b};
      assign arith   = is_sub ? sub_w[W-1:0] : add_w[W-1:0];
      assign arith_c = is_sub ? sub_w[W] : add_w[W];
   end

   always_comb begin
      res   = '0;
      carry = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB, OP_CMP: begin
            res   = arith;
            carry = arith_c;
         end
         OP_SHL: begin
            res   = {a[W-2:0], 1'b0};
            carry = a[W-1];
         end
         OP_SHR: begin
            res   = {1'b0, a[W-1:1]};
            carry = a[0];
         end
         default: begin
            res   = '0;
            carry = 1'b0;
         end
      endcase
   end

   assign zero = (res == '0);

endmodule

// File: rtl/aexu_move.sv
`timescale 1ns/1ps
module aexu_move
   import aexu_pkg::*;
#(
   parameter int W    = 32,
   localparam int HW  = W / 2
) (
   input  mode_e         src_mode,
   input  logic [HW-1:0] imm,
   input  logic [HW-1:0] src_lo,
   input  mode_e         dst_mode,
   output logic [W-1:0]  data,
   output logic [W-1:0]  mask
);

   logic [HW-1:0] half;

   assign half = (src_mode == MODE_IMM) ? imm : src_lo;
   assign data = {half, half};

   always_comb begin
      unique case (dst_mode)
         MODE_LOW:  mask = {{HW{1'b0}}, {HW{1'b1}}};
         MODE_HIGH: mask = {{HW{1'b1}}, {HW{1'b0}}};
         default:   mask = '0;
      endcase
   end

endmodule

// File: rtl/alu_exec_unit.sv
`timescale 1ns/1ps
module alu_exec_unit
   import aexu_pkg::*;
#(
   parameter int W            = 32,
   parameter int NREGS        = 16,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int IW          = $clog2(NREGS),
   localparam int HW          = W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en,
   input  logic              op_kind,
   input  logic [2:0]        alu_op,
   input  logic [1:0]        a_mode,
   input  logic [IW-1:0]     a_idx,
   input  logic [1:0]        b_mode,
   input  logic [IW-1:0]     b_idx,
   input  logic [1:0]        d_mode,
   input  logic [IW-1:0]     d_idx,
   input  logic [HW-1:0]     imm,
   output logic              fault,
   output logic [FLAG_W-1:0] flags_q,
   input  logic [IW-1:0]     peek_idx,
   output logic [W-1:0]      peek_data
);

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("alu_exec_unit: W must be even and at least 4");
   end
   if (NREGS < 8 || NREGS != (1 << IW)) begin : g_bad_depth
      $error("alu_exec_unit: NREGS must be a power of two, at least 8");
   end

   kind_e   kind;
   alu_op_e op;
   mode_e   ma, mb, md;

   assign kind = kind_e'(op_kind);
   assign op   = alu_op_e'(alu_op);
   assign ma   = mode_e'(a_mode);
   assign mb   = mode_e'(b_mode);
   assign md   = mode_e'(d_mode);

   // Bundle legality
   logic alu_ok, mov_ok, legal;
   assign alu_ok = (ma == MODE_REG) && (mb == MODE_REG) && (md == MODE_REG)
                   && (alu_op <= 3'd4);
   assign mov_ok = ((md == MODE_LOW) || (md == MODE_HIGH))
                   && ((ma == MODE_IMM) || (ma == MODE_REG));
   assign legal  = (kind == KIND_ALU) ? alu_ok : mov_ok;
   assign fault  = exec_en && !legal;

   logic go, alu_go, mov_go;
   assign go     = exec_en && legal;
   assign alu_go = go && (kind == KIND_ALU);
   assign mov_go = go && (kind == KIND_MOVE);

   // Datapath
   logic [W-1:0] rd_a, rd_b;
   logic [W-1:0] alu_res, mov_data, mov_mask;
   logic         alu_c, alu_z;
   logic         wr_en;
   logic [W-1:0] wr_data, wr_mask;

   aexu_regfile #(.W(W), .NREGS(NREGS)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (a_idx),
      .rd_a     (rd_a),
      .rd_b_idx (b_idx),
      .rd_b     (rd_b),
      .rd_p_idx (peek_idx),
      .rd_p     (peek_data),
      .wr_en    (wr_en),
      .wr_idx   (d_idx),
      .wr_data  (wr_data),
      .wr_mask  (wr_mask)
   );

   aexu_alu #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op    (op),
      .a     (rd_a),
      .b     (rd_b),
      .res   (alu_res),
      .carry (alu_c),
      .zero  (alu_z)
   );

   aexu_move #(.W(W)) u_mov (
      .src_mode (ma),
      .imm      (imm),
      .src_lo   (rd_a[HW-1:0]),
      .dst_mode (md),
      .data     (mov_data),
      .mask     (mov_mask)
   );

   assign wr_en   = mov_go || (alu_go && (op != OP_CMP));
   assign wr_data = mov_go ? mov_data : alu_res;
   assign wr_mask = mov_go ? mov_mask : {W{1'b1}};

   // Flag register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (alu_go) begin
         flags_q[FLAG_Z] <= alu_z;
         flags_q[FLAG_C] <= alu_c;
      end
   end

endmodule

// File: rtl/aexu_chk.sv
`timescale 1ns/1ps
module aexu_chk #(
   parameter int W  = 32,
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          exec_en,
   input logic          op_kind,
   input logic [2:0]    alu_op,
   input logic          fault,
   input logic [1:0]    flags_q,
   input logic          wr_en,
   input logic [W-1:0]  alu_res,
   input logic [W-1:0]  rd_a
);

   // R11: idle cycles leave flags and fault alone
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |-> !fault && !wr_en);
   assert_idle_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(flags_q));

   // R10: rejected bundle touches nothing
   assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !wr_en);
   assert_fault_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> $stable(flags_q));

   // R8 / R9: moves keep the flags
   assert_move_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !fault && op_kind |=> $stable(flags_q));

   // R4: compare writes no register
   assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !op_kind && alu_op == 3'd4 |-> !wr_en);

   // R7: zero flag follows the result
   assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !fault && !op_kind |=> flags_q[0] == ($past(alu_res) == '0));

   // R5: shift left carry is old top bit
   assert_shl_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_en && !fault && !op_kind && alu_op == 3'd2 |=> flags_q[1] == $past(rd_a[W-1]));

endmodule

bind alu_exec_unit aexu_chk #(.W(W), .IW(IW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .exec_en (exec_en),
   .op_kind (op_kind),
   .alu_op  (alu_op),
   .fault   (fault),
   .flags_q (flags_q),
   .wr_en   (wr_en),
   .alu_res (alu_res),
   .rd_a    (rd_a)
);

// File: tb/test_alu_exec_unit.sv
`timescale 1ns/1ps
module test_alu_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic        op_kind = 1'b0;
   logic [2:0]  alu_op = '0;
   logic [1:0]  a_mode = '0, b_mode = '0, d_mode = '0;
   logic [3:0]  a_idx = '0, b_idx = '0, d_idx = '0, peek_idx = '0;
   logic [15:0] imm = '0;
   logic        fault;
   logic [1:0]  flags_q;
   logic [31:0] peek_data;

   always #2 clk = ~clk;

   alu_exec_unit i_alu_exec_unit (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_kind(op_kind),
      .alu_op(alu_op), .a_mode(a_mode), .a_idx(a_idx), .b_mode(b_mode),
      .b_idx(b_idx), .d_mode(d_mode), .d_idx(d_idx), .imm(imm),
      .fault(fault), .flags_q(flags_q), .peek_idx(peek_idx),
      .peek_data(peek_data)
   );

   typedef struct {
      bit          state;
      bit          exp_fault;
      logic [31:0] exp_rd;
      logic [1:0]  exp_fl;
      string       tag;
   } item_t;

   item_t       sb[$];
   int          n_chk = 0, n_fail = 0;
   logic [31:0] mregs [16];
   logic [1:0]  mflags = 2'b00;
   bit          done = 0;

   // Monitor: one scoreboard item per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (fault !== it.exp_fault) begin
            n_fail++;
            $display("FAIL %s: fault=%0b expected %0b", it.tag, fault, it.exp_fault);
         end else if (it.state && (peek_data !== it.exp_rd || flags_q !== it.exp_fl)) begin
            n_fail++;
            $display("FAIL %s: reg=%h flags=%b expected reg=%h flags=%b",
                     it.tag, peek_data, flags_q, it.exp_rd, it.exp_fl);
         end
      end
   end

   task automatic peek(input logic [3:0] idx, input string tag);
      item_t it;
      @(posedge clk); #1;
      exec_en  = 1'b0;
      peek_idx = idx;
      it.state = 1; it.exp_fault = 0; it.exp_rd = mregs[idx];
      it.exp_fl = mflags; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic run(input logic en, input logic k, input logic [2:0] op,
                      input logic [1:0] am, input logic [3:0] ai,
                      input logic [1:0] bm, input logic [3:0] bi,
                      input logic [1:0] dm, input logic [3:0] di,
                      input logic [15:0] iv, input string tag);
      item_t       it;
      bit          bad;
      logic [31:0] va, vb, res;
      logic [32:0] s;
      logic        c;
      logic [15:0] half;
      va = mregs[ai]; vb = mregs[bi];
      if (!k) bad = !(am == 2'd1 && bm == 2'd1 && dm == 2'd1) || op > 3'd4;
      else    bad = !(dm == 2'd2 || dm == 2'd3) || !(am == 2'd0 || am == 2'd1);
      @(posedge clk); #1;
      exec_en = en; op_kind = k; alu_op = op; a_mode = am; a_idx = ai;
      b_mode = bm; b_idx = bi; d_mode = dm; d_idx = di; imm = iv;
      it.state = 0; it.exp_fault = en && bad; it.exp_rd = '0; it.exp_fl = '0;
      it.tag = tag;
      sb.push_back(it);
      if (en && !bad) begin
         if (!k) begin
            res = '0; c = 0;
            case (op)
               3'd0: begin s = {1'b0, va} + {1'b0, vb}; res = s[31:0]; c = s[32]; end
               3'd1, 3'd4: begin res = va - vb; c = (va < vb); end
               3'd2: begin res = va << 1; c = va[31]; end
               default: begin res = va >> 1; c = va[0]; end
            endcase
            mflags = {c, res == 32'd0};
            if (op != 3'd4) mregs[di] = res;
         end else begin
            half = (am == 2'd0) ? iv : va[15:0];
            if (dm == 2'd2) mregs[di][15:0] = half;
            else            mregs[di][31:16] = half;
         end
      end
      peek(di, tag);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mregs[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      peek(4'd0, "R1 reset r0");
      peek(4'd9, "R1 reset r9");
      peek(4'd15, "R1 reset r15");
      run(1, 1, 0, 0, 0, 0, 0, 2, 1, 16'hFFFF, "R8 low move");
      run(1, 1, 0, 0, 0, 0, 0, 3, 1, 16'hFFFF, "R9 high move");
      run(1, 1, 0, 0, 0, 0, 0, 2, 2, 16'h0001, "R8 low move r2");
      run(1, 0, 0, 1, 1, 1, 2, 1, 3, 0, "R2 R7 add wrap to zero");
      run(1, 1, 0, 0, 0, 0, 0, 3, 4, 16'h1234, "R9 high move keeps flags");
      run(1, 1, 0, 0, 0, 0, 0, 2, 4, 16'h5678, "R8 low move keeps high half");
      run(1, 0, 0, 1, 4, 1, 2, 1, 5, 0, "R2 add no carry");
      run(1, 0, 1, 1, 2, 1, 4, 1, 6, 0, "R3 sub with borrow");
      run(1, 0, 1, 1, 4, 1, 4, 1, 7, 0, "R3 R7 sub equal gives zero");
      run(1, 0, 4, 1, 2, 1, 1, 1, 2, 0, "R4 cmp no writeback");
      run(1, 0, 4, 1, 4, 1, 4, 1, 4, 0, "R4 R7 cmp equal");
      run(1, 0, 2, 1, 1, 1, 0, 1, 8, 0, "R5 shl top bit to carry");
      run(1, 0, 2, 1, 4, 1, 0, 1, 12, 0, "R5 shl no carry");
      run(1, 0, 3, 1, 2, 1, 0, 1, 9, 0, "R6 R7 shr to zero");
      run(1, 0, 3, 1, 1, 1, 0, 1, 10, 0, "R6 shr logical");
      run(1, 1, 0, 1, 4, 0, 0, 3, 11, 16'hAAAA, "R12 move from register");
      run(1, 1, 0, 1, 1, 0, 0, 2, 11, 16'h0000, "R12 low move from register");
      run(1, 0, 0, 0, 1, 1, 2, 1, 13, 0, "R10 alu imm operand");
      run(1, 0, 5, 1, 1, 1, 2, 1, 13, 0, "R10 alu bad op");
      run(1, 1, 0, 0, 0, 0, 0, 1, 14, 16'h1111, "R10 move bad dest");
      run(1, 1, 0, 2, 1, 0, 0, 2, 14, 16'h1111, "R10 move bad source");
      run(0, 0, 0, 1, 1, 1, 2, 1, 13, 0, "R11 disabled add");
      run(0, 1, 0, 0, 0, 0, 0, 2, 1, 16'h0000, "R11 disabled move");
      repeat (3) @(posedge clk);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule